// File: doc/BRIEF.md
# Two-Wire Transition Token Codec

This block moves 9-bit tokens (an 8-bit byte plus a control flag) across a pair of wires with no clock between the two ends. Each bit is sent as a single toggle, and the wire that toggles gives the bit's value. A token is ten toggles: eight for the byte with the most significant bit first, one for the control flag, and a final toggle that brings the one wire still high back low. After every token both wires are therefore at rest.

The transmit half takes a token on a valid/ready port and produces the toggles. A configuration input sets the minimum number of clock cycles between two toggles, so a slow receiver or slow pads can keep up. A stall input can pause sending between any two toggles. The receive half watches two lines that are already synchronised to its clock. It counts toggles to rebuild each token and gives a one-cycle valid pulse when the token is complete. If both lines toggle in one sample, or the last toggle does not leave both lines low, it sets a sticky error flag, drops the partial token, and waits for both lines to be low before it decodes again.

The two halves have separate pins. A system can join them back to back or use them for two different links.

Top module: `tlc_codec`

## Requirements
- R1: Each transition toggles exactly one transmit line. A toggle on line 0 (`tx_w0`) means bit 0 and a toggle on line 1 (`tx_w1`) means bit 1.
- R2: A token takes exactly ten transitions, in this order: `tx_data[7]` down to `tx_data[0]`, then `tx_ctl`, then the return transition.
- R3: The return transition leaves both transmit lines low. `tx_ready` is high only while no token is in flight, and a token is accepted in a cycle where `tx_valid` and `tx_ready` are both high.
- R4: Two successive transmit transitions are at least max(`cfg_gap`,1) cycles apart. Inside a token, with `tx_hold` low, the spacing is exactly max(`cfg_gap`,1).
- R5: While `tx_hold` is high no transmit line changes. When it falls, sending resumes with the next transition of the same token.
- R6: The receiver rebuilds each token. `rx_valid` is high for exactly one cycle, in the cycle after the sample that holds the tenth transition, with `rx_data`/`rx_ctl` equal to the byte and flag that were sent.
- R7: If both receive lines toggle in the same sample, `rx_err` goes high and stays high until reset. The partial token is dropped and produces no `rx_valid`.
- R8: After an error the receiver ignores all transitions until it samples both lines low. It then decodes the next token normally.
- R9: If the tenth transition leaves a receive line high, this is a framing error with the same handling as R7. No token is produced.
- R10: During and after reset both transmit lines are low, `tx_ready` is high, and `rx_valid` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_gap | input | GAP_W | Minimum cycles between transmit transitions (0 acts as 1) |
| tx_hold | input | 1 | Stall transmit transitions while high |
| tx_valid | input | 1 | Token offered for transmission |
| tx_data | input | 8 | Token byte |
| tx_ctl | input | 1 | Token control flag |
| tx_ready | output | 1 | Transmitter idle, can accept a token |
| tx_w0 | output | 1 | Transmit line 0 (a toggle carries a 0 bit) |
| tx_w1 | output | 1 | Transmit line 1 (a toggle carries a 1 bit) |
| rx_w0 | input | 1 | Receive line 0, already synchronised |
| rx_w1 | input | 1 | Receive line 1, already synchronised |
| rx_valid | output | 1 | One-cycle pulse: received token available |
| rx_data | output | 8 | Received byte |
| rx_ctl | output | 1 | Received control flag |
| rx_err | output | 1 | Sticky error: double toggle or bad return |

## Verification
On the receive side, a bit decode and the error check can fall in the same sample when both lines toggle together. The bench makes this happen by driving the receive lines directly, partway through a token. It then expects the error flag to be set, no token pulse, silence for as long as the lines stay off the all-low state, and a clean decode once they return to it. On the transmit side, a stall request can arrive in the very cycle the gap timer opens. Random stalls, mixed with gap values from 0 to 7, are judged by an independent monitor that decodes the transmit lines and measures the cycles between edges.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int BYTE_W = 8;
  localparam int TOK_W  = BYTE_W + 1;
  localparam int STEPS  = TOK_W + 1;          // bits plus return transition
  localparam int IDX_W  = $clog2(STEPS);

  typedef struct packed {
    logic              ctl;
    logic [BYTE_W-1:0] data;
  } tok_t;

  // Bit carried by transition k (0..TOK_W-1): byte MSB first, then flag.
  function automatic logic tok_bit(tok_t t, logic [IDX_W-1:0] k);
    logic b;
    b = t.ctl;
    for (int i = 0; i < BYTE_W; i++) begin
      if (int'(k) == BYTE_W - 1 - i) b = t.data[i];
    end
    return b;
  endfunction

  // Fold received bit for transition k into the partial token.
  function automatic tok_t push_bit(tok_t t, logic [IDX_W-1:0] k, logic b);
    tok_t r;
    r = t;
    if (int'(k) < BYTE_W) r.data = {t.data[BYTE_W-2:0], b};
    else                  r.ctl  = b;
    return r;
  endfunction

  // The return transition toggles whichever line is still high.
  function automatic logic ret_wire(logic [1:0] lv);
    return lv[1];
  endfunction
endpackage

// File: rtl/tlc_gap_timer.sv
module tlc_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap,
  input  logic             fire,
  output logic             open
);
  logic [GAP_W-1:0] cnt_q;

  assign open = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= (gap == '0) ? '0 : gap - GAP_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - GAP_W'(1);
    end
  end

  AST_FIRE_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> open); // R4
endmodule

// File: rtl/tlc_tx.sv
module tlc_tx
  import tlc_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] gap,
  input  logic             hold,
  input  logic             in_valid,
  input  tok_t             in_tok,
  output logic             in_ready,
  output logic [1:0]       line
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;
  tok_t             tok;
  logic [1:0]       lv;
  logic             gap_open;
  logic             step;
  logic             last_step;
  logic             sel_w;
  logic [GAP_W:0]   since_q;

  function automatic logic [GAP_W:0] min_space(logic [GAP_W-1:0] g);
    return (g == '0) ? (GAP_W+1)'(1) : {1'b0, g};
  endfunction

  tlc_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk  (clk),
    .rst_n(rst_n),
    .gap  (gap),
    .fire (step),
    .open (gap_open)
  );

  assign step      = busy && gap_open && !hold;
  assign last_step = step && (idx == LAST_IDX);
  assign in_ready  = !busy;
  assign line      = lv;

  always_comb begin
    if (idx == LAST_IDX) sel_w = ret_wire(lv);
    else                 sel_w = tok_bit(tok, idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      tok  <= '0;
      lv   <= 2'b00;
    end else if (!busy) begin
      if (in_valid) begin
        busy <= 1'b1;
        tok  <= in_tok;
        idx  <= '0;
      end
    end else if (step) begin
      lv  <= lv ^ (sel_w ? 2'b10 : 2'b01);
      idx <= last_step ? '0 : idx + IDX_W'(1);
      if (last_step) busy <= 1'b0;
    end
  end

  // cycles since the last transition, saturating (assertion support)
  always_ff @(posedge clk) begin
    if (!rst_n)              since_q <= '0;
    else if (step)           since_q <= (GAP_W+1)'(1);
    else if (~&since_q)      since_q <= since_q + (GAP_W+1)'(1);
  end

  AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line ^ $past(line)) <= 1); // R1
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (line == 2'b00)); // R3
  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx != '0) |-> (since_q >= min_space(gap))); // R4
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(line)); // R5
endmodule

// File: rtl/tlc_rx.sv
module tlc_rx
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line,
  output logic       out_valid,
  output tok_t       out_tok,
  output logic       err
);
  typedef enum logic {RX_RUN, RX_HUNT} rx_st_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  rx_st_t           st;
  logic [1:0]       prev;
  logic [1:0]       edges;
  logic             two_edges;
  logic             one_edge;
  logic             hunting;
  logic [IDX_W-1:0] idx;
  tok_t             acc;

  assign edges     = line ^ prev;
  assign two_edges = &edges;
  assign one_edge  = ^edges;
  assign hunting   = (st == RX_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RX_RUN;
      prev      <= 2'b00;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_tok   <= '0;
      err       <= 1'b0;
    end else begin
      prev      <= line;
      out_valid <= 1'b0;
      case (st)
        RX_RUN: begin
          if (two_edges) begin
            err <= 1'b1;
            st  <= RX_HUNT;
            idx <= '0;
          end else if (one_edge) begin
            if (idx == LAST_IDX) begin
              idx <= '0;
              if (line == 2'b00) begin
                out_valid <= 1'b1;
                out_tok   <= acc;
              end else begin
                err <= 1'b1;
                st  <= RX_HUNT;
              end
            end else begin
              acc <= push_bit(acc, idx, edges[1]);
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: begin
          idx <= '0;
          if (line == 2'b00) st <= RX_RUN;
        end
      endcase
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R7
  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |=> !out_valid); // R8
  AST_RETURN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(line) == 2'b00)); // R9
endmodule

// File: rtl/tlc_codec.sv
module tlc_codec
  import tlc_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              tx_hold,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ctl,
  output logic              tx_ready,
  output logic              tx_w0,
  output logic              tx_w1,
  input  logic              rx_w0,
  input  logic              rx_w1,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_ctl,
  output logic              rx_err
);
  tok_t       tx_tok;
  tok_t       rx_tok;
  logic [1:0] tx_line;

  assign tx_tok = '{ctl: tx_ctl, data: tx_data};
  assign tx_w0  = tx_line[0];
  assign tx_w1  = tx_line[1];
  assign rx_data = rx_tok.data;
  assign rx_ctl  = rx_tok.ctl;

  tlc_tx #(.GAP_W(GAP_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .gap     (cfg_gap),
    .hold    (tx_hold),
    .in_valid(tx_valid),
    .in_tok  (tx_tok),
    .in_ready(tx_ready),
    .line    (tx_line)
  );

  tlc_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line     ({rx_w1, rx_w0}),
    .out_valid(rx_valid),
    .out_tok  (rx_tok),
    .err      (rx_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rx_valid && !rx_err && tx_ready)); // R10
endmodule

// File: tb/tlc_codec_test.sv
module tlc_codec_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_gap = 8'd0;
  logic       tx_hold = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_ctl = 1'b0;
  logic       tx_ready, tx_w0, tx_w1;
  logic       rx_w0, rx_w1, rx_valid, rx_ctl, rx_err;
  logic [7:0] rx_data;
  logic [1:0] drv_l = 2'b00;
  logic       drv_sel = 1'b0;
  logic       hold_rand = 1'b0;

  always #10 clk = ~clk;

  assign rx_w0 = drv_sel ? drv_l[0] : tx_w0;
  assign rx_w1 = drv_sel ? drv_l[1] : tx_w1;

  tlc_codec #(.GAP_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .tx_hold(tx_hold),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctl(tx_ctl), .tx_ready(tx_ready),
    .tx_w0(tx_w0), .tx_w1(tx_w1), .rx_w0(rx_w0), .rx_w1(rx_w1),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctl(rx_ctl), .rx_err(rx_err)
  );

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  logic [8:0] rx_q[$];

  // transmit-line monitor state
  int         mk = 0;
  logic [7:0] mbyte = 0;
  logic       mctl = 0;
  logic [1:0] mlast = 0;
  int         cyc = 0;
  int         last_cyc = 0;
  logic       hold_seen = 0;
  int         rx_cnt = 0;
  logic [8:0] rx_last = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  function automatic int min_space(input logic [7:0] g);
    return (g == 0) ? 1 : int'(g);
  endfunction

  // independent decode of the transmit lines
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] cur, d;
      cyc++;
      cur = {tx_w1, tx_w0};
      d = cur ^ mlast;
      if (d != 2'b00) begin
        chk($countones(d) == 1, "R1", "lines per transition", $countones(d), 1);
        if (mk >= 1) begin
          if (!hold_seen)
            chk(cyc - last_cyc == min_space(cfg_gap), "R4", "exact spacing",
                cyc - last_cyc, min_space(cfg_gap));
          else
            chk(cyc - last_cyc >= min_space(cfg_gap), "R4", "min spacing",
                cyc - last_cyc, min_space(cfg_gap));
        end
        if (mk < 8) mbyte = {mbyte[6:0], d[1]};
        else if (mk == 8) mctl = d[1];
        else begin
          chk(cur == 2'b00, "R3", "lines after return", cur, 0);
          if (exp_q.size() == 0) chk(0, "R2", "unexpected token", {mctl, mbyte}, 0);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({mctl, mbyte} == e, "R2", "wire token", {mctl, mbyte}, e);
          end
        end
        mk = (mk == 9) ? 0 : mk + 1;
        last_cyc = cyc;
        mlast = cur;
        hold_seen = tx_hold;
      end else begin
        hold_seen = hold_seen | tx_hold;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt++;
      rx_last = {rx_ctl, rx_data};
      if (!drv_sel) begin
        if (rx_q.size() == 0) chk(0, "R6", "unexpected rx token", rx_last, 0);
        else begin
          logic [8:0] e;
          e = rx_q.pop_front();
          chk(rx_last == e, "R6", "rx token", rx_last, e);
        end
      end
    end
  end

  initial begin
    forever begin
      tick;
      if (hold_rand) tx_hold = ($urandom % 6 == 0);
    end
  end

  task automatic do_reset;
    rst_n = 1'b0;
    drv_l = 2'b00;
    tx_valid = 1'b0;
    tx_hold = 1'b0;
    repeat (3) tick;
    chk({tx_w1, tx_w0} == 2'b00, "R10", "lines in reset", {tx_w1, tx_w0}, 0);
    chk(tx_ready == 1'b1, "R10", "ready in reset", tx_ready, 1);
    mk = 0; mlast = 0; hold_seen = 0;
    exp_q.delete(); rx_q.delete();
    rst_n = 1'b1;
    tick;
    chk(rx_valid == 1'b0 && rx_err == 1'b0, "R10", "rx after reset",
        {rx_valid, rx_err}, 0);
  endtask

  task automatic send(input logic [7:0] d, input logic c);
    tx_data = d;
    tx_ctl = c;
    tx_valid = 1'b1;
    while (!tx_ready) tick;
    exp_q.push_back({c, d});
    rx_q.push_back({c, d});
    tick;
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R3", "ready while busy", tx_ready, 0);
  endtask

  task automatic drain;
    while (!(tx_ready && mk == 0 && exp_q.size() == 0 && rx_q.size() == 0)) tick;
    repeat (2) tick;
  endtask

  task automatic drv_token(input logic [7:0] d, input logic c);
    for (int k = 0; k < 9; k++) begin
      logic b;
      b = (k < 8) ? d[7-k] : c;
      tick;
      drv_l[b] = ~drv_l[b];
    end
    tick;
    if (drv_l[1]) drv_l[1] = 1'b0;
    else          drv_l[0] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset;

    // directed loopback corner tokens
    cfg_gap = 8'd0;
    send(8'h00, 1'b0);
    send(8'hFF, 1'b1);
    send(8'h5A, 1'b0);
    drain;
    cfg_gap = 8'd3;
    send(8'h81, 1'b1);
    drain;

    // R5: stall mid-token
    cfg_gap = 8'd2;
    send(8'hB4, 1'b0);
    while (mk != 3) tick;
    tx_hold = 1'b1;
    begin
      logic [1:0] snap;
      snap = {tx_w1, tx_w0};
      for (int i = 0; i < 6; i++) begin
        tick;
        chk({tx_w1, tx_w0} == snap, "R5", "lines frozen by hold", {tx_w1, tx_w0}, snap);
      end
    end
    tx_hold = 1'b0;
    drain;

    // random stream with random stalls and gaps
    hold_rand = 1'b1;
    for (int n = 0; n < 48; n++) begin
      if (n % 8 == 0) begin
        drain;
        cfg_gap = 8'($urandom % 8);
      end
      send(8'($urandom), 1'($urandom));
    end
    hold_rand = 1'b0;
    tx_hold = 1'b0;
    drain;

    // direct receive drive
    drv_sel = 1'b1;
    do_reset;
    drv_token(8'hC3, 1'b1);
    tick;
    chk(rx_valid == 1'b1, "R6", "valid after tenth edge", rx_valid, 1);
    chk({rx_ctl, rx_data} == 9'h1C3, "R6", "direct token", {rx_ctl, rx_data}, 9'h1C3);
    tick;
    chk(rx_valid == 1'b0, "R6", "valid single cycle", rx_valid, 0);

    // R7 / R8: double toggle mid-token, then hunt
    do_reset;
    begin
      int c0;
      c0 = rx_cnt;
      tick; drv_l[1] = ~drv_l[1];
      tick; drv_l[0] = ~drv_l[0];
      tick; drv_l[1] = ~drv_l[1];
      tick; drv_l[0] = ~drv_l[0];
      tick; drv_l = ~drv_l;
      tick;
      chk(rx_err == 1'b1, "R7", "error on double toggle", rx_err, 1);
      for (int i = 0; i < 3; i++) begin
        drv_l[0] = ~drv_l[0];
        tick;
      end
      tick;
      chk(rx_cnt == c0, "R7", "no token from dropped part", rx_cnt, c0);
      chk(rx_cnt == c0, "R8", "edges ignored while hunting", rx_cnt, c0);
      drv_l[1] = ~drv_l[1];
      drv_token(8'hA5, 1'b0);
      tick;
      chk(rx_valid == 1'b1 && {rx_ctl, rx_data} == 9'h0A5, "R8", "decode after resync",
          {rx_valid, rx_ctl, rx_data}, 10'h2A5);
      chk(rx_err == 1'b1, "R7", "error flag sticky", rx_err, 1);
    end

    // R9: bad return transition
    do_reset;
    begin
      int c0;
      c0 = rx_cnt;
      for (int i = 0; i < 9; i++) begin
        tick;
        drv_l[0] = ~drv_l[0];
      end
      tick;
      drv_l[1] = ~drv_l[1];
      tick;
      chk(rx_err == 1'b1, "R9", "framing error", rx_err, 1);
      tick;
      chk(rx_cnt == c0, "R9", "no token on bad return", rx_cnt, c0);
      drv_l = 2'b00;
      drv_token(8'h3C, 1'b1);
      tick;
      chk(rx_valid == 1'b1 && {rx_ctl, rx_data} == 9'h13C, "R9", "decode after framing error",
          {rx_valid, rx_ctl, rx_data}, 10'h33C);
    end

    drv_sel = 1'b0;
    chk(exp_q.size() == 0, "R2", "all tokens seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule